// File: doc/BRIEF.md
# Multi-region CCD field sequencer

This block follows the vertical readout of a CCD field one horizontal line at a time. A field-start strobe clears a line counter, and each line-start strobe advances it. For every line the block reports which region of the field the line falls in, and which vertical timing sequence that region uses. It also reports the region's sweep and multiplier enables and how many pixels the line holds. It raises a flag on the line or lines that carry the sensor-gate pulses, and on those lines it gives the per-output gate enables, the pattern selects and a second vertical pattern group. Waveform generation belongs to a separate block, which consumes these outputs.

Six field sets are held in a register bank and written whole through a parallel write port. A separate write port fills a table of ten per-sequence line lengths. At each field start the set named by `field_sel` is copied into a shadow copy, and that copy drives every output until the next field start. A write to the bank therefore changes nothing in the field that is running. Writes to the line-length table take effect at once.

Top module: `ccd_field_seq`

## Requirements
- R1: `line_idx` is 0 in the cycle after `field_start`. It rises by 1 in the cycle after each `line_start`. `field_start` wins when both strobes arrive together. The count saturates at 4095.
- R2: `region_idx` equals the number of the six change positions (entry k in `wr_cp[12k+11:12k]` of the loaded set) that are at or below `line_idx`. The positions must be in ascending order.
- R3: `seq_num` is the 4-bit selector of the current region, where region r sits at `wr_seqsel[4r+3:4r]`. A selector value from 10 to 15 is reported as 0.
- R4: `sweep_en` and `multi_en` equal bit `region_idx` of the loaded sweep mask and multiplier mask.
- R5: `line_len` is the table entry for `seq_num`, written through `seq_we`/`seq_addr`/`seq_len`. On the final line (`line_idx + 1 == vdlen`) it is the loaded last-line pixel count instead.
- R6: `gate_line` is high when `line_idx` equals the first gate line. It is also high when the second-line enable is set and `line_idx` equals the second gate line.
- R7: On a gate line, `gate_en[i]` (gate output i+1) is the inverse of mask bit i. Off a gate line all enables are 0. `gate_pat` carries the 2-bit pattern per output, with output i+1 at bits [2i+1:2i].
- R8: `vpat2_act` equals `gate_line`. `vpat2_grp` is the loaded second pattern group, and values 10 to 15 are reported as 0.
- R9: `field_start` loads set `field_sel`, and a value of 6 or 7 loads set 0. A write to a set does not change any output until the next `field_start`.
- R10: After reset every set has all change positions at 4095, all masks high and every other field at 0, and the line-length table is 0. So the outputs show line 0, region 0, sequence 0, length 0, and `gate_line` high with all gate enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | Field-start strobe, one cycle |
| line_start | input | 1 | Line-start strobe, one cycle |
| field_sel | input | 3 | Field set loaded at field start |
| wr_en | input | 1 | Write a whole field set |
| wr_field | input | 3 | Target set (0 to 5; others dropped) |
| wr_cp | input | 72 | Six 12-bit change positions |
| wr_seqsel | input | 28 | Seven 4-bit sequence selectors |
| wr_sweep | input | 7 | Sweep enable per region |
| wr_multi | input | 7 | Multiplier enable per region |
| wr_vdlen | input | 12 | Lines in the field |
| wr_hdlast | input | 12 | Pixels in the final line |
| wr_vpat2 | input | 4 | Second pattern group for the gate line |
| wr_gmask | input | 5 | Gate mask, high suppresses |
| wr_gpat | input | 10 | 2-bit pattern per gate output |
| wr_gline1 | input | 12 | First gate line |
| wr_gline2 | input | 12 | Second gate line |
| wr_gline2_en | input | 1 | Enables the second gate line |
| seq_we | input | 1 | Write line-length table |
| seq_addr | input | 4 | Sequence index (0 to 9) |
| seq_len | input | 12 | Pixels per line for that sequence |
| line_idx | output | 12 | Current line in the field |
| region_idx | output | 3 | Current region 0 to 6 |
| seq_num | output | 4 | Active sequence 0 to 9 |
| sweep_en | output | 1 | Sweep mode active |
| multi_en | output | 1 | Multiplier mode active |
| line_len | output | 12 | Pixel length of current line |
| gate_line | output | 1 | Current line carries gate pulses |
| gate_en | output | 5 | Per-output gate enable |
| gate_pat | output | 10 | Per-output pattern select |
| vpat2_grp | output | 4 | Second pattern group |
| vpat2_act | output | 1 | Second pattern group applies now |

## Verification
The line counter and the shadow set are the only registers between the strobes and the outputs. Every output therefore settles one clock edge after the `field_start` or `line_start` that caused it. A write to the line-length table likewise shows one edge after `seq_we`. The bench drives each strobe for a single cycle on a falling edge, then samples at the next falling edge, which lies half a period after the edge that took the strobe. The sweep walks every line of all six sets past the field length and compares every output with values worked out arithmetically. Shadowing, a collision between the two strobes, an out-of-range select and saturation each get their own case.

// File: rtl/ccd_field_pkg.sv
package ccd_field_pkg;
  localparam int LINE_W      = 12;
  localparam int SEL_W       = 4;
  localparam int NUM_CP      = 6;
  localparam int NUM_REG     = NUM_CP + 1;
  localparam int NUM_SEQ     = 10;
  localparam int NUM_GATE    = 5;
  localparam int PAT_W       = 2;
  localparam int NUM_FIELDS  = 6;
  localparam int FIELD_IDX_W = $clog2(NUM_FIELDS);
  localparam int REG_IDX_W   = $clog2(NUM_REG);

  typedef struct packed {
    logic [NUM_CP-1:0][LINE_W-1:0]  cp;
    logic [NUM_REG-1:0][SEL_W-1:0]  seqsel;
    logic [NUM_REG-1:0]             sweep;
    logic [NUM_REG-1:0]             multi;
    logic [LINE_W-1:0]              vdlen;
    logic [LINE_W-1:0]              hdlast;
    logic [SEL_W-1:0]               vpat2;
    logic [NUM_GATE-1:0]            gmask;
    logic [NUM_GATE*PAT_W-1:0]      gpat;
    logic [LINE_W-1:0]              gline1;
    logic [LINE_W-1:0]              gline2;
    logic                           gline2_en;
  } field_cfg_t;

  function automatic field_cfg_t cfg_reset_value();
    field_cfg_t c;
    c       = '0;
    c.cp    = '1;
    c.gmask = '1;
    return c;
  endfunction
endpackage

// File: rtl/ccd_field_bank.sv
module ccd_field_bank
  import ccd_field_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [FIELD_IDX_W-1:0] wr_idx,
  input  field_cfg_t             wr_cfg,
  input  logic                   load,
  input  logic [FIELD_IDX_W-1:0] load_idx,
  output field_cfg_t             active_cfg
);
  field_cfg_t bank_q [NUM_FIELDS];
  field_cfg_t active_q, active_d;
  logic [FIELD_IDX_W-1:0] load_sel;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_entry
    logic       ent_we;
    field_cfg_t ent_d;
    always_comb begin
      ent_we = wr_en && (wr_idx == FIELD_IDX_W'(f));
      ent_d  = ent_we ? wr_cfg : bank_q[f];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[f] <= cfg_reset_value();
      else        bank_q[f] <= ent_d;
    end
  end

  always_comb begin
    load_sel = (int'(load_idx) < NUM_FIELDS) ? load_idx : '0;
    active_d = load ? bank_q[load_sel] : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= cfg_reset_value();
    else        active_q <= active_d;
  end

  assign active_cfg = active_q;

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q)); // R9
endmodule

// File: rtl/ccd_line_counter.sv
module ccd_line_counter #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              line_start,
  output logic [LINE_W-1:0] line_q
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  logic [LINE_W-1:0] line_d;
  logic              step_en;

  always_comb begin
    step_en = line_start && (line_q != LINE_MAX);
    if (field_start)  line_d = '0;
    else if (step_en) line_d = line_q + 1'b1;
    else              line_d = line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (line_q == '0)); // R1
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !field_start && line_q != LINE_MAX) |=> (line_q == $past(line_q) + 1'b1)); // R1
  AST_LINE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_start && line_q == LINE_MAX) |=> (line_q == LINE_MAX)); // R1
endmodule

// File: rtl/ccd_region_decode.sv
module ccd_region_decode
  import ccd_field_pkg::*;
(
  input  logic [LINE_W-1:0]             line,
  input  logic [NUM_CP-1:0][LINE_W-1:0] cp,
  output logic [REG_IDX_W-1:0]          region
);
  logic [NUM_CP-1:0] hit;

  for (genvar k = 0; k < NUM_CP; k++) begin : g_cmp
    assign hit[k] = (cp[k] <= line);
  end

  always_comb begin
    region = '0;
    for (int k = 0; k < NUM_CP; k++) begin
      if (hit[k]) region = region + 1'b1;
    end
  end
endmodule

// File: rtl/ccd_field_seq.sv
module ccd_field_seq
  import ccd_field_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          field_start,
  input  logic                          line_start,
  input  logic [FIELD_IDX_W-1:0]        field_sel,
  input  logic                          wr_en,
  input  logic [FIELD_IDX_W-1:0]        wr_field,
  input  logic [NUM_CP*LINE_W-1:0]      wr_cp,
  input  logic [NUM_REG*SEL_W-1:0]      wr_seqsel,
  input  logic [NUM_REG-1:0]            wr_sweep,
  input  logic [NUM_REG-1:0]            wr_multi,
  input  logic [LINE_W-1:0]             wr_vdlen,
  input  logic [LINE_W-1:0]             wr_hdlast,
  input  logic [SEL_W-1:0]              wr_vpat2,
  input  logic [NUM_GATE-1:0]           wr_gmask,
  input  logic [NUM_GATE*PAT_W-1:0]     wr_gpat,
  input  logic [LINE_W-1:0]             wr_gline1,
  input  logic [LINE_W-1:0]             wr_gline2,
  input  logic                          wr_gline2_en,
  input  logic                          seq_we,
  input  logic [SEL_W-1:0]              seq_addr,
  input  logic [LINE_W-1:0]             seq_len,
  output logic [LINE_W-1:0]             line_idx,
  output logic [REG_IDX_W-1:0]          region_idx,
  output logic [SEL_W-1:0]              seq_num,
  output logic                          sweep_en,
  output logic                          multi_en,
  output logic [LINE_W-1:0]             line_len,
  output logic                          gate_line,
  output logic [NUM_GATE-1:0]           gate_en,
  output logic [NUM_GATE*PAT_W-1:0]     gate_pat,
  output logic [SEL_W-1:0]              vpat2_grp,
  output logic                          vpat2_act
);
  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  field_cfg_t wr_cfg, act;
  always_comb begin
    wr_cfg.cp        = wr_cp;
    wr_cfg.seqsel    = wr_seqsel;
    wr_cfg.sweep     = wr_sweep;
    wr_cfg.multi     = wr_multi;
    wr_cfg.vdlen     = wr_vdlen;
    wr_cfg.hdlast    = wr_hdlast;
    wr_cfg.vpat2     = wr_vpat2;
    wr_cfg.gmask     = wr_gmask;
    wr_cfg.gpat      = wr_gpat;
    wr_cfg.gline1    = wr_gline1;
    wr_cfg.gline2    = wr_gline2;
    wr_cfg.gline2_en = wr_gline2_en;
  end

  ccd_field_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_field),
    .wr_cfg     (wr_cfg),
    .load       (field_start),
    .load_idx   (field_sel),
    .active_cfg (act)
  );

  logic [LINE_W-1:0] line_q;
  ccd_line_counter #(.LINE_W(LINE_W)) u_lines (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .field_start (field_start),
    .line_start  (line_start),
    .line_q      (line_q)
  );

  logic [REG_IDX_W-1:0] region;
  ccd_region_decode u_region (
    .line   (line_q),
    .cp     (act.cp),
    .region (region)
  );

  // Per-sequence line length table, written live.
  logic [LINE_W-1:0] len_q [NUM_SEQ];
  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_len
    logic              len_we;
    logic [LINE_W-1:0] len_d;
    always_comb begin
      len_we = seq_we && (seq_addr == SEL_W'(s));
      len_d  = len_we ? seq_len : len_q[s];
    end
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) len_q[s] <= '0;
      else            len_q[s] <= len_d;
    end
  end

  logic [REG_IDX_W-1:0] reg_sel;
  logic [SEL_W-1:0]     sel_raw;
  logic                 last_line;
  logic                 hit1, hit2;

  always_comb begin
    reg_sel    = (int'(region) < NUM_REG) ? region : '0;
    sel_raw    = act.seqsel[reg_sel];
    seq_num    = (int'(sel_raw) < NUM_SEQ) ? sel_raw : '0;
    sweep_en   = act.sweep[reg_sel];
    multi_en   = act.multi[reg_sel];
    last_line  = (({1'b0, line_q} + 1'b1) == {1'b0, act.vdlen});
    line_len   = last_line ? act.hdlast : len_q[seq_num];
    hit1       = (line_q == act.gline1);
    hit2       = act.gline2_en && (line_q == act.gline2);
    gate_line  = hit1 || hit2;
    gate_en    = gate_line ? ~act.gmask : '0;
    gate_pat   = act.gpat;
    vpat2_grp  = (int'(act.vpat2) < NUM_SEQ) ? act.vpat2 : '0;
    vpat2_act  = gate_line;
    line_idx   = line_q;
    region_idx = region;
  end

  AST_SEQ_VALID: assert property (@(posedge clk) disable iff (!rst_int_n)
    int'(seq_num) < NUM_SEQ); // R3
  AST_GATE_MASKED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (gate_en & act.gmask) == '0); // R7
  AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !gate_line |-> (gate_en == '0)); // R7
  AST_REGION_MONO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (line_start && !field_start) |=> (region >= $past(region))); // R2
endmodule

// File: tb/tb_ccd_field_seq.sv
module tb_ccd_field_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        field_start = 0, line_start = 0, wr_en = 0, seq_we = 0;
  logic [2:0]  field_sel = 0, wr_field = 0;
  logic [71:0] wr_cp = '0;
  logic [27:0] wr_seqsel = '0;
  logic [6:0]  wr_sweep = '0, wr_multi = '0;
  logic [11:0] wr_vdlen = '0, wr_hdlast = '0, wr_gline1 = '0, wr_gline2 = '0, seq_len = '0;
  logic [3:0]  wr_vpat2 = '0, seq_addr = '0;
  logic [4:0]  wr_gmask = '0;
  logic [9:0]  wr_gpat = '0;
  logic        wr_gline2_en = 0;

  logic [11:0] line_idx, line_len;
  logic [2:0]  region_idx;
  logic [3:0]  seq_num, vpat2_grp;
  logic        sweep_en, multi_en, gate_line, vpat2_act;
  logic [4:0]  gate_en;
  logic [9:0]  gate_pat;

  ccd_field_seq dut (.*);

  int checks = 0, errors = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench-side model of the programmed field sets.
  function automatic int m_cp(int f, int k);    return 2 + 3*k + f; endfunction
  function automatic int m_sel(int f, int r);   return (3*r + f) % 16; endfunction
  function automatic int m_sweep(int f);        return (5*f + 1) & 127; endfunction
  function automatic int m_multi(int f);        return 85 ^ f; endfunction
  function automatic int m_vdlen(int f);        return 24 + f; endfunction
  function automatic int m_hdlast(int f);       return 100 + f; endfunction
  function automatic int m_vpat2(int f);        return (3*f) % 16; endfunction
  function automatic int m_gmask(int f);        return (7*f) & 31; endfunction
  function automatic int m_gpat(int f);         return (435 ^ (37*f)) & 1023; endfunction
  function automatic int m_gl1(int f);          return 3 + f; endfunction
  function automatic int m_gl2(int f);          return 20 + f; endfunction
  function automatic int m_gl2en(int f);        return f & 1; endfunction
  function automatic int m_seqlen(int s);       return 200 + 13*s; endfunction

  function automatic int e_region(int f, int ln);
    int n = 0;
    for (int k = 0; k < 6; k++) if (m_cp(f, k) <= ln) n++;
    return n;
  endfunction
  function automatic int e_seq(int f, int ln);
    int s = m_sel(f, e_region(f, ln));
    return (s > 9) ? 0 : s;
  endfunction
  function automatic int e_gate(int f, int ln);
    return (ln == m_gl1(f)) || (m_gl2en(f) != 0 && ln == m_gl2(f));
  endfunction

  task automatic write_field(int f);
    @(negedge clk);
    wr_en = 1; wr_field = 3'(f);
    for (int k = 0; k < 6; k++) wr_cp[12*k +: 12] = 12'(m_cp(f, k));
    for (int r = 0; r < 7; r++) wr_seqsel[4*r +: 4] = 4'(m_sel(f, r));
    wr_sweep = 7'(m_sweep(f)); wr_multi = 7'(m_multi(f));
    wr_vdlen = 12'(m_vdlen(f)); wr_hdlast = 12'(m_hdlast(f));
    wr_vpat2 = 4'(m_vpat2(f)); wr_gmask = 5'(m_gmask(f)); wr_gpat = 10'(m_gpat(f));
    wr_gline1 = 12'(m_gl1(f)); wr_gline2 = 12'(m_gl2(f)); wr_gline2_en = 1'(m_gl2en(f));
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic start_field(int sel);
    @(negedge clk); field_start = 1; field_sel = 3'(sel);
    @(negedge clk); field_start = 0;
  endtask

  task automatic next_line();
    @(negedge clk); line_start = 1;
    @(negedge clk); line_start = 0;
  endtask

  task automatic check_line(int f, int ln);
    int s = e_seq(f, ln);
    int r = e_region(f, ln);
    int g = e_gate(f, ln);
    int v = (m_vpat2(f) > 9) ? 0 : m_vpat2(f);
    chk("R1 line", line_idx, ln);
    chk("R2 region", region_idx, r);
    chk("R3 seq", seq_num, s);
    chk("R4 sweep", sweep_en, (m_sweep(f) >> r) & 1);
    chk("R4 multi", multi_en, (m_multi(f) >> r) & 1);
    chk("R5 len", line_len, (ln + 1 == m_vdlen(f)) ? m_hdlast(f) : m_seqlen(s));
    chk("R6 gate line", gate_line, g);
    chk("R7 gate en", gate_en, g ? (~m_gmask(f) & 31) : 0);
    chk("R7 gate pat", gate_pat, m_gpat(f));
    chk("R8 vpat2 act", vpat2_act, g);
    chk("R8 vpat2 grp", vpat2_grp, v);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 line", line_idx, 0);
    chk("R10 region", region_idx, 0);
    chk("R10 seq", seq_num, 0);
    chk("R10 len", line_len, 0);
    chk("R10 gate line", gate_line, 1);
    chk("R10 gate en", gate_en, 0);

    for (int s = 0; s < 10; s++) begin
      @(negedge clk); seq_we = 1; seq_addr = 4'(s); seq_len = 12'(m_seqlen(s));
    end
    @(negedge clk); seq_we = 0;
    // R5: the table is live, so line 0 of the reset set shows sequence 0's length.
    chk("R5 live table", line_len, m_seqlen(0));
    for (int f = 0; f < 6; f++) write_field(f);

    // Full sweep of every set (R1..R8).
    for (int f = 0; f < 6; f++) begin
      start_field(f);
      check_line(f, 0);
      for (int ln = 1; ln <= m_vdlen(f) + 1; ln++) begin
        next_line();
        check_line(f, ln);
      end
    end

    // R9: a write to the running set takes effect only at the next field start.
    start_field(1);
    next_line();
    @(negedge clk);
    wr_en = 1; wr_field = 3'd1; wr_cp = '1; wr_vdlen = 12'd2; wr_hdlast = 12'd77;
    @(negedge clk); wr_en = 0;
    check_line(1, 1);
    start_field(1);
    next_line();
    chk("R9 reload region", region_idx, 0);
    chk("R9 reload len", line_len, 77);
    write_field(1);

    // R9: out-of-range selects load set 0.
    start_field(7);
    check_line(0, 0);
    start_field(6);
    next_line();
    check_line(0, 1);

    // R1: field start beats line start in the same cycle.
    start_field(2);
    next_line(); next_line();
    @(negedge clk); field_start = 1; line_start = 1; field_sel = 3'd2;
    @(negedge clk); field_start = 0; line_start = 0;
    chk("R1 collision", line_idx, 0);

    // R1: saturation at 4095.
    @(negedge clk); line_start = 1;
    repeat (4200) @(negedge clk);
    line_start = 0;
    @(negedge clk);
    chk("R1 saturate", line_idx, 4095);
    chk("R2 top region", region_idx, 6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule